// File: doc/BRIEF.md
# Cartridge Bank Register Controller

This block holds the banking state of a game-cartridge memory mapper. It watches CPU writes to the upper half of the address space and turns them into two program-ROM bank numbers, six pattern-ROM bank numbers, a nametable mirroring choice, a single-screen page choice and a scanline interrupt. Address translation into ROM is left to the logic around it. That logic reads the bank numbers straight from the output ports.

Bank numbers load in two steps. A write to the select location names one of eight targets. A write to the data location then loads that target. The interrupt part is a down-counter with a reload latch. A one-cycle pulse clocks it once per scanline. The interrupt line is sticky: it stays high until software acknowledges it.

Top module: `cart_bank_ctrl`

## Requirements
- R1: A write takes effect on the rising clock edge where `wr_en` is high. Only address bits 15, 14, 13 and 0 are decoded, and address bit 15 must be 1. Writes with address bit 15 = 0 change nothing. A write where bits {14,13,0} = 3'b011 (for example 0xA001) also changes nothing.
- R2: A write with bits {14,13,0} = 3'b000 (select) stores the target number from data bits 2:0 and the page-steer flag from data bit 7. Data bits 6:3 do not matter. The next data write goes to that stored target.
- R3: A data write ({14,13,0} = 3'b001) to target 0 or 1 loads `chr_banks` slot 0 or slot 1 with the data byte, with bit 0 forced to 0.
- R4: A data write to targets 2, 3, 4 or 5 loads `chr_banks` slots 2, 3, 4 or 5 with the data byte unchanged. Slot k sits in bits 8k+7:8k.
- R5: A data write to target 6 loads `prg_bank0`. A data write to target 7 loads `prg_bank1`.
- R6: A write with {14,13,0} = 3'b010 sets `mirror_horiz` to data bit 0 (1 means horizontal, 0 means vertical). This happens only when `four_screen` is 0. When `four_screen` is 1, the write is ignored.
- R7: When `onescreen_en` is 1, some data writes also set `screen_high` to the inverse of data bit 7. This applies to target 2 when the steer flag is 1, and to target 0 when the steer flag is 0. Other data writes leave `screen_high` unchanged.
- R8: A write with {14,13,0} = 3'b100 loads the scanline counter. A write with 3'b101 loads the reload latch.
- R9: On each `line_tick`, the counter reloads from the latch if it is zero, and otherwise decrements by 1. If the new counter value is zero and the interrupt is enabled, `irq` goes high on that edge. A write with 3'b111 enables the interrupt. While the interrupt is disabled, the counter still runs but `irq` is not raised.
- R10: A write with {14,13,0} = 3'b110 disables the interrupt and drops `irq` on that edge. Otherwise `irq` stays high once set, through further ticks.
- R11: After synchronous reset: program banks are 0 and 1, pattern slots are 0, 2, 4, 5, 6 and 7, `mirror_horiz` = 0, `screen_high` = 0, `irq` = 0, and the counter, latch, enable and select register are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| line_tick | input | 1 | One-cycle pulse per scanline |
| four_screen | input | 1 | Strap: freezes the mirroring choice |
| onescreen_en | input | 1 | Strap: lets data writes steer the single-screen page |
| prg_bank0 | output | 8 | Program bank number 0 |
| prg_bank1 | output | 8 | Program bank number 1 |
| chr_banks | output | 48 | Six pattern bank numbers, slot k in bits 8k+7:8k |
| mirror_horiz | output | 1 | 1 = horizontal mirroring, 0 = vertical |
| screen_high | output | 1 | Single-screen page: 1 = high, 0 = low |
| irq | output | 1 | Scanline interrupt, held until acknowledged |

## Verification
The hardest state to reach is the counter's internal value, because it never appears on a port. The bench only sees it through the tick on which `irq` rises. It sets the counter and the latch to chosen values, enables the interrupt, and counts ticks until the rise. That exposes both the plain decrement and the reload-from-zero path, including a latch of zero that fires on every tick. Runs with the interrupt disabled, and extra ticks after the rise, show the interrupt gating and the sticky hold. The steer-flag dependence of the single-screen page is covered by a sweep over every target with both flag values and several data bytes.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;

    localparam int CPU_DW  = 8;
    localparam int BANK_W  = 8;
    localparam int CNT_W   = 8;
    localparam int NUM_PRG = 2;
    localparam int NUM_CHR = 6;
    localparam int NUM_2K  = 2;
    localparam int TGT_W   = $clog2(NUM_PRG + NUM_CHR);

    typedef enum logic [3:0] {
        WK_NONE,
        WK_SELECT,
        WK_DATA,
        WK_MIRROR,
        WK_SPARE,
        WK_CNT_LOAD,
        WK_LATCH_LOAD,
        WK_IRQ_OFF,
        WK_IRQ_ON
    } wr_kind_e;

    typedef struct packed {
        wr_kind_e            kind;
        logic [CPU_DW-1:0]   data;
    } wr_cmd_t;

    // key = {A15, A14, A13, A0}
    function automatic wr_kind_e classify(input logic en, input logic [3:0] key);
        if (!en || !key[3]) return WK_NONE;
        unique case (key[2:0])
            3'b000:  return WK_SELECT;
            3'b001:  return WK_DATA;
            3'b010:  return WK_MIRROR;
            3'b011:  return WK_SPARE;
            3'b100:  return WK_CNT_LOAD;
            3'b101:  return WK_LATCH_LOAD;
            3'b110:  return WK_IRQ_OFF;
            default: return WK_IRQ_ON;
        endcase
    endfunction

    function automatic logic [BANK_W-1:0] chr_reset(input int slot);
        return (slot < NUM_2K) ? BANK_W'(2 * slot) : BANK_W'(slot + 2);
    endfunction

endpackage

// File: rtl/cart_wr_decode.sv
module cart_wr_decode
    import cart_bank_pkg::*;
(
    input  logic              wr_en,
    input  logic [3:0]        addr_key,
    input  logic [CPU_DW-1:0] wr_data,
    output wr_cmd_t           cmd
);

    always_comb begin
        cmd.kind = classify(wr_en, addr_key);
        cmd.data = wr_data;
    end

endmodule

// File: rtl/cart_bank_file.sv
module cart_bank_file
    import cart_bank_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  wr_cmd_t                           cmd,
    input  logic                              four_screen,
    input  logic                              onescreen_en,
    output logic [NUM_PRG-1:0][BANK_W-1:0]    prg_q,
    output logic [NUM_CHR-1:0][BANK_W-1:0]    chr_q,
    output logic                              mirror_h,
    output logic                              scr_high
);

    logic [TGT_W-1:0] sel_tgt;
    logic             sel_steer;
    logic             hit_data;
    logic             steer_hit;

    assign hit_data  = (cmd.kind == WK_DATA);
    assign steer_hit = hit_data && onescreen_en &&
                       (sel_steer ? (sel_tgt == TGT_W'(2)) : (sel_tgt == TGT_W'(0)));

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_tgt   <= '0;
            sel_steer <= 1'b0;
            mirror_h  <= 1'b0;
            scr_high  <= 1'b0;
        end else begin
            if (cmd.kind == WK_SELECT) begin
                sel_tgt   <= cmd.data[TGT_W-1:0];
                sel_steer <= cmd.data[CPU_DW-1];
            end
            if (cmd.kind == WK_MIRROR && !four_screen)
                mirror_h <= cmd.data[0];
            if (steer_hit)
                scr_high <= ~cmd.data[CPU_DW-1];
        end
    end

    for (genvar g = 0; g < NUM_CHR; g++) begin : g_chr
        logic [BANK_W-1:0] r;
        always_ff @(posedge clk) begin
            if (rst)
                r <= chr_reset(g);
            else if (hit_data && sel_tgt == TGT_W'(g)) begin
                if (g < NUM_2K) r <= {cmd.data[BANK_W-1:1], 1'b0};
                else            r <= cmd.data[BANK_W-1:0];
            end
        end
        assign chr_q[g] = r;
    end

    for (genvar g = 0; g < NUM_PRG; g++) begin : g_prg
        logic [BANK_W-1:0] r;
        always_ff @(posedge clk) begin
            if (rst)
                r <= BANK_W'(g);
            else if (hit_data && sel_tgt == TGT_W'(NUM_CHR + g))
                r <= cmd.data[BANK_W-1:0];
        end
        assign prg_q[g] = r;
    end

    // R6: strap holds mirroring still
    p_strap_freeze_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd.kind == WK_MIRROR && four_screen) |=> $stable(mirror_h));

    // R2: banks move only on data writes
    p_banks_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd.kind != WK_DATA) |=> ($stable(prg_q) && $stable(chr_q)));

    // R3: a 2 KB slot load leaves bit 0 clear
    p_even_slot_r3: assert property (@(posedge clk) disable iff (rst)
        (hit_data && sel_tgt == '0) |=> (chr_q[0][0] == 1'b0));

    // R7: page moves only on a steer hit
    p_page_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd.kind != WK_DATA) |=> $stable(scr_high));

endmodule

// File: rtl/cart_scan_irq.sv
module cart_scan_irq
    import cart_bank_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_cmd_t cmd,
    input  logic    line_tick,
    output logic    irq
);

    logic [CNT_W-1:0] cnt_q, latch_q, cnt_step;
    logic             en_q, pend_q;
    logic             tick_live;

    assign tick_live = line_tick && (cmd.kind != WK_CNT_LOAD);
    assign cnt_step  = (cnt_q == '0) ? latch_q : cnt_q - CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            latch_q <= '0;
            en_q    <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            if (cmd.kind == WK_CNT_LOAD)
                cnt_q <= cmd.data[CNT_W-1:0];
            else if (tick_live)
                cnt_q <= cnt_step;

            if (cmd.kind == WK_LATCH_LOAD)
                latch_q <= cmd.data[CNT_W-1:0];

            if (cmd.kind == WK_IRQ_OFF) begin
                en_q   <= 1'b0;
                pend_q <= 1'b0;
            end else begin
                if (cmd.kind == WK_IRQ_ON)
                    en_q <= 1'b1;
                if (tick_live && en_q && cnt_step == '0)
                    pend_q <= 1'b1;
            end
        end
    end

    assign irq = pend_q;

    // R10: acknowledge drops the line
    p_ack_drops_r10: assert property (@(posedge clk) disable iff (rst)
        (cmd.kind == WK_IRQ_OFF) |=> !irq);

    // R10: held until acknowledge
    p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (irq && cmd.kind != WK_IRQ_OFF) |=> irq);

    // R9: a new request coincides with an empty counter
    p_rise_at_zero_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (cnt_q == '0));

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
    import cart_bank_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [15:0]                wr_addr,
    input  logic [CPU_DW-1:0]          wr_data,
    input  logic                       line_tick,
    input  logic                       four_screen,
    input  logic                       onescreen_en,
    output logic [BANK_W-1:0]          prg_bank0,
    output logic [BANK_W-1:0]          prg_bank1,
    output logic [NUM_CHR*BANK_W-1:0]  chr_banks,
    output logic                       mirror_horiz,
    output logic                       screen_high,
    output logic                       irq
);

    wr_cmd_t                            cmd;
    logic [NUM_PRG-1:0][BANK_W-1:0]     prg_q;
    logic [NUM_CHR-1:0][BANK_W-1:0]     chr_q;
    logic                               unused_addr_bits;

    assign unused_addr_bits = ^wr_addr[12:1];

    cart_wr_decode u_dec (
        .wr_en    (wr_en),
        .addr_key ({wr_addr[15], wr_addr[14], wr_addr[13], wr_addr[0]}),
        .wr_data  (wr_data),
        .cmd      (cmd)
    );

    cart_bank_file u_banks (
        .clk          (clk),
        .rst          (rst),
        .cmd          (cmd),
        .four_screen  (four_screen),
        .onescreen_en (onescreen_en),
        .prg_q        (prg_q),
        .chr_q        (chr_q),
        .mirror_h     (mirror_horiz),
        .scr_high     (screen_high)
    );

    cart_scan_irq u_irq (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .line_tick (line_tick),
        .irq       (irq)
    );

    assign prg_bank0 = prg_q[0];
    assign prg_bank1 = prg_q[1];
    assign chr_banks = chr_q;

    // R1: no decoded action when address bit 15 is low
    p_low_half_idle_r1: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_addr[15]) |=> ($stable(prg_bank0) && $stable(prg_bank1) &&
                                     $stable(chr_banks) && $stable(mirror_horiz)));

endmodule

// File: tb/sim_cart_bank_ctrl.sv
module sim_cart_bank_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        line_tick = 1'b0;
    logic        four_screen = 1'b0;
    logic        onescreen_en = 1'b0;
    logic [7:0]  prg_bank0, prg_bank1;
    logic [47:0] chr_banks;
    logic        mirror_horiz, screen_high, irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic [7:0] e_prg [2];
    logic [7:0] e_chr [6];
    logic       e_mir, e_scr;
    logic [2:0] m_tgt;
    logic       m_steer;

    always #4 clk = ~clk;

    cart_bank_ctrl u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .line_tick(line_tick), .four_screen(four_screen), .onescreen_en(onescreen_en),
        .prg_bank0(prg_bank0), .prg_bank1(prg_bank1), .chr_banks(chr_banks),
        .mirror_horiz(mirror_horiz), .screen_high(screen_high), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string ctx);
        chk({"R5 prg0 ", ctx}, prg_bank0, e_prg[0]);
        chk({"R5 prg1 ", ctx}, prg_bank1, e_prg[1]);
        for (int k = 0; k < 6; k++)
            chk({(k < 2) ? "R3 chr " : "R4 chr ", ctx}, chr_banks[8*k +: 8], e_chr[k]);
        chk({"R6 mirror ", ctx}, mirror_horiz, e_mir);
        chk({"R7 page ", ctx}, screen_high, e_scr);
    endtask

    task automatic model_reset();
        e_prg[0] = 8'd0; e_prg[1] = 8'd1;
        e_chr[0] = 8'd0; e_chr[1] = 8'd2; e_chr[2] = 8'd4;
        e_chr[3] = 8'd5; e_chr[4] = 8'd6; e_chr[5] = 8'd7;
        e_mir = 1'b0; e_scr = 1'b0; m_tgt = 3'd0; m_steer = 1'b0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a[15]) begin
            case ({a[14], a[13], a[0]})
                3'b000: begin m_tgt = d[2:0]; m_steer = d[7]; end
                3'b001: begin
                    if (onescreen_en && (m_steer ? (m_tgt == 3'd2) : (m_tgt == 3'd0)))
                        e_scr = ~d[7];
                    if (m_tgt < 3'd2)      e_chr[m_tgt] = {d[7:1], 1'b0};
                    else if (m_tgt < 3'd6) e_chr[m_tgt] = d;
                    else                   e_prg[m_tgt - 3'd6] = d;
                end
                3'b010: if (!four_screen) e_mir = d[0];
                default: ;
            endcase
        end
    endtask

    task automatic tick();
        @(negedge clk);
        line_tick = 1'b1;
        @(negedge clk);
        line_tick = 1'b0;
    endtask

    function automatic logic [7:0] pat(input int i);
        case (i)
            0: return 8'h00;
            1: return 8'hFF;
            2: return 8'h5A;
            3: return 8'hA5;
            default: return 8'h81;
        endcase
    endfunction

    // runs N ticks, expects irq low for the first N-1 and high after the N-th
    task automatic expect_fire(input int n, input string tag);
        for (int t = 1; t <= n; t++) begin
            tick();
            chk(tag, irq, (t == n) ? 1 : 0);
        end
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog expired");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_all("R11 reset");
        chk("R11 irq reset", irq, 0);

        // R2 R3 R4 R5 R7: all targets, both steer flags, several bytes, two aliases
        for (int sb = 0; sb < 2; sb++)
            for (int t = 0; t < 8; t++)
                for (int di = 0; di < 5; di++) begin
                    onescreen_en = (di != 2);
                    wr((di[0]) ? 16'h9FFE : 16'h8000, {sb[0], 4'(di * 3), t[2:0]});
                    wr((di[0]) ? 16'h8001 : 16'h9F7F, pat(di) ^ 8'(t));
                    check_all("sweep");
                end

        // R6 mirror writes with and without strap
        four_screen = 1'b0;
        wr(16'hA000, 8'h01); check_all("mirror set");
        wr(16'hBFFE, 8'hFE); check_all("mirror clear alias");
        wr(16'hA000, 8'h01); check_all("mirror set");
        four_screen = 1'b1;
        wr(16'hA000, 8'h00); check_all("strap holds");
        four_screen = 1'b0;

        // R1 ignored writes: low half and the spare location
        wr(16'h0000, 8'h06);
        wr(16'h2001, 8'hEE);
        wr(16'h6000, 8'h07);
        wr(16'h7FFF, 8'hFF);
        wr(16'hA001, 8'h00);
        check_all("R1 ignored");
        wr(16'h8001, 8'h3C);
        check_all("R1 select kept");

        // R8 R9: counter N with latch 3, counts N ticks to the rise
        wr(16'hC001, 8'd3);
        for (int n = 1; n <= 6; n++) begin
            wr(16'hE000, 8'h00);
            wr(16'hC000, 8'(n));
            wr(16'hE001, 8'h00);
            expect_fire(n, "R8 R9 countdown");
            tick();
            chk("R10 sticky after tick", irq, 1);
            wr(16'hE000, 8'h00);
            chk("R10 ack clears", irq, 0);
        end

        // R9 reload from zero: latch 2, counter 0 -> rise after 3 ticks
        wr(16'hDFFF, 8'd2);
        wr(16'hC000, 8'd0);
        wr(16'hFFFF, 8'h00);
        expect_fire(3, "R9 reload path");
        wr(16'hE000, 8'h00);

        // R9 latch 0 fires on every tick
        wr(16'hC001, 8'd0);
        wr(16'hC000, 8'd0);
        wr(16'hE001, 8'h00);
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R9 zero latch fires", irq, 1);
            wr(16'hE000, 8'h00);
            chk("R10 ack", irq, 0);
            wr(16'hE001, 8'h00);
        end
        wr(16'hE000, 8'h00);

        // R9 disabled counter reaching zero raises nothing
        wr(16'hC001, 8'd5);
        wr(16'hC000, 8'd2);
        tick(); tick();
        chk("R9 disabled no irq", irq, 0);
        tick();
        chk("R9 disabled after reload", irq, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule